// File: doc/BRIEF.md
# Sector Hamming Parity Generator

This block builds a 24-bit line-parity code over a 512-byte data sector while the bytes stream past on a byte-wide input. Each data bit has a 12-bit bit address (byte index times 8 plus bit index). For every address bit k there are two parity terms. The "even" term is the XOR of the data bits whose address bit k is 0. The "odd" term is the XOR of the data bits whose address bit k is 1. Address bit k corresponds to weight 2^k, so the weights run from 1 to 2048.

A page of 2048 bytes is handled as four sectors in sequence. After the last byte of a sector, the accumulated code is stored in the next of four result slots and the accumulator starts over. A single clear input empties every slot, drops any partly accumulated sector and points back at slot 0, ready for a new page. Any slot can be read at any time through a selector, either as a 32-bit raw word or as three packed code bytes. The code is stored as computed, without inversion.

Top module: `sector_parity_page`

## Requirements
- R1: The terms for weights 1, 2 and 4 depend on the bit index within a byte. For k in 0..2, the odd term k is the XOR of the data bits whose bit index has bit k set, and the even term k is the XOR of the rest.
- R2: The terms for weights 8 to 2048 depend on the byte index i (0..511). For k in 3..11, the byte's parity goes to the odd term k when bit k-3 of i is 1, and to the even term k otherwise.
- R3: The raw word `rd_word` carries the even terms for weights 1..2048 in bits 11:0 (weight 2^k at bit k) and the odd terms in bits 27:16 (weight 2^k at bit 16+k). Bits 15:12 and 31:28 always read 0.
- R4: `rd_code` packs the selected code into three bytes, from least significant to most significant:
  - bits 7:0 hold raw bits 7:0;
  - bits 15:8 hold raw bits 23:16;
  - bits 23:16 hold the even terms for weights 256..2048 in the low nibble and the odd terms for those weights in the high nibble.
- R5: The code is not inverted, so a sector of all-zero bytes yields an all-zero code.
- R6: Completed sectors fill slots 0, 1, 2, 3 in that order. The fifth sector after a clear goes back to slot 0 and overwrites it.
- R7: `sector_done` is high for exactly the one cycle after the 512th accepted byte of a sector. `page_done` is high in that same cycle only when the sector just stored went to slot 3.
- R8: A `clr` cycle zeroes all slots, the running code and the byte count, and selects slot 0. It takes priority over a byte strobed in the same cycle. After reset the block is in the same state.
- R9: A byte is accepted only when `din_vld` and `en` are both high. Other cycles change neither the code nor the byte count.
- R10: A stored slot keeps its value until a later sector overwrites it or a clear empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Clears all slots and the accumulator, selects slot 0 |
| en | input | 1 | Accumulation enable |
| din_vld | input | 1 | Data byte strobe |
| din | input | 8 | Data byte |
| rd_sel | input | 2 | Result slot to read |
| rd_word | output | 32 | Raw result word of the selected slot |
| rd_code | output | 24 | Packed three-byte code of the selected slot |
| sector_done | output | 1 | One-cycle pulse after a sector completes |
| page_done | output | 1 | One-cycle pulse after the fourth sector of a page |

## Verification
The first stimulus is a sector with one set bit at byte 300, bit 5. Its code must equal that bit address in the odd half and the complement of the address in the even half, which pins down both the term split and the byte packing. A single bit at address 0 sets every even term; this separates the three bit-index weights from the byte-index weights. The bench also runs all-zero sectors, which show that the code is not inverted. It runs random sectors broken up by strobes with only one of `din_vld` or `en` high; these catch accumulation of rejected bytes and errors in the slot order over the wrap to a fifth sector. Finally, a clear that arrives together with a strobe in the middle of a sector checks the clear priority against a behavioural per-clock model.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned RAW_W  = 32;
  localparam int unsigned HALF_W = 16;

  // lanes of a byte whose bit index has bit k set
  function automatic logic [7:0] lane_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/sp_terms.sv
module sp_terms #(
  parameter int IDX_W = 9,
  parameter int NW    = 12
) (
  input  logic [7:0]       din,
  input  logic [IDX_W-1:0] idx,
  output logic [NW-1:0]    ev_t,
  output logic [NW-1:0]    od_t
);
  import sp_pkg::*;

  logic par;
  assign par = ^din;

  genvar k;
  generate
    for (k = 0; k < NW; k++) begin : g_w
      if (k < 3) begin : g_lane
        assign od_t[k] = ^(din &  lane_mask(k));
        assign ev_t[k] = ^(din & ~lane_mask(k));
      end else begin : g_byte
        assign od_t[k] =  idx[k-3] & par;
        assign ev_t[k] = ~idx[k-3] & par;
      end
    end
  endgenerate
endmodule

// File: rtl/sp_seq.sv
module sp_seq #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  parameter int IDX_W        = 9,
  parameter int SLOT_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  output logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot,
  output logic              last,
  output logic              sector_done,
  output logic              page_done
);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SECTORS - 1);

  logic [IDX_W-1:0]  idx_d;
  logic [SLOT_W-1:0] slot_d;
  logic              sd_d, pd_d;

  assign last = take && (idx == IDX_LAST);

  always_comb begin
    idx_d  = idx;
    slot_d = slot;
    sd_d   = 1'b0;
    pd_d   = 1'b0;
    if (clr) begin
      idx_d  = '0;
      slot_d = '0;
    end else if (last) begin
      idx_d  = '0;
      slot_d = (slot == SLOT_LAST) ? '0 : slot + 1'b1;
      sd_d   = 1'b1;
      pd_d   = (slot == SLOT_LAST);
    end else if (take) begin
      idx_d  = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx         <= '0;
      slot        <= '0;
      sector_done <= 1'b0;
      page_done   <= 1'b0;
    end else begin
      idx         <= idx_d;
      slot        <= slot_d;
      sector_done <= sd_d;
      page_done   <= pd_d;
    end
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int SECTORS = 4,
  parameter int SLOT_W  = 2,
  parameter int W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [W-1:0]      wdata,
  input  logic [SLOT_W-1:0] rsel,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] slot_v [SECTORS];

  genvar s;
  generate
    for (s = 0; s < SECTORS; s++) begin : g_slot
      logic [W-1:0] q;
      logic         we;
      assign we = wr && (wslot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (we)  q <= wdata;
      end
      assign slot_v[s] = q;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < SECTORS; i++)
      if (rsel == SLOT_W'(i)) rdata = slot_v[i];
  end
endmodule

// File: rtl/sector_parity_page.sv
module sector_parity_page #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECTORS      = 4,
  localparam int IDX_W  = $clog2(SECTOR_BYTES),
  localparam int NW     = IDX_W + 3,
  localparam int SLOT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int CODE_W = 2 * NW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din_vld,
  input  logic [7:0]        din,
  input  logic [SLOT_W-1:0] rd_sel,
  output logic [31:0]       rd_word,
  output logic [CODE_W-1:0] rd_code,
  output logic              sector_done,
  output logic              page_done
);
  import sp_pkg::*;
  localparam int PAD = HALF_W - NW;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic              take, last;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] slot;
  logic [NW-1:0]     ev_t, od_t, ev_q, od_q, ev_n, od_n, ev_d, od_d;
  logic [CODE_W-1:0] rd_raw;

  assign take = din_vld && en && !clr;

  sp_seq #(.SECTOR_BYTES(SECTOR_BYTES), .SECTORS(SECTORS),
           .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .take(take), .idx(idx),
    .slot(slot), .last(last), .sector_done(sector_done), .page_done(page_done));

  sp_terms #(.IDX_W(IDX_W), .NW(NW)) u_terms (
    .din(din), .idx(idx), .ev_t(ev_t), .od_t(od_t));

  assign ev_n = ev_q ^ ev_t;
  assign od_n = od_q ^ od_t;

  always_comb begin
    ev_d = ev_q;
    od_d = od_q;
    if (clr || last) begin
      ev_d = '0;
      od_d = '0;
    end else if (take) begin
      ev_d = ev_n;
      od_d = od_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ev_q <= '0;
      od_q <= '0;
    end else begin
      ev_q <= ev_d;
      od_q <= od_d;
    end
  end

  sp_bank #(.SECTORS(SECTORS), .SLOT_W(SLOT_W), .W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_n_i), .clr(clr), .wr(last), .wslot(slot),
    .wdata({od_n, ev_n}), .rsel(rd_sel), .rdata(rd_raw));

  // slot layout: {odd terms, even terms}
  assign rd_word = {{PAD{1'b0}}, rd_raw[CODE_W-1:NW], {PAD{1'b0}}, rd_raw[NW-1:0]};
  assign rd_code = {rd_raw[CODE_W-1:CODE_W-4], rd_raw[NW-1:NW-4],
                    rd_raw[NW+7:NW], rd_raw[7:0]};
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              en,
  input logic              din_vld,
  input logic [SLOT_W-1:0] rd_sel,
  input logic [31:0]       rd_word,
  input logic [23:0]       rd_code,
  input logic              sector_done,
  input logic              page_done
);
  AST_RAW_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[15:12] == 4'h0) && (rd_word[31:28] == 4'h0)); // R3

  AST_CODE_PACKING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_code == {rd_word[27:24], rd_word[11:8], rd_word[23:16], rd_word[7:0]}); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_word == 32'h0)); // R8

  AST_PAGE_WITH_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> sector_done); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sector_done |=> !sector_done); // R7

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sector_done) |-> $past(din_vld && en && !clr)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(din_vld && en) && !clr) |=> (!$stable(rd_sel) || $stable(rd_word))); // R9
endmodule

bind sector_parity_page sp_checker #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .din_vld(din_vld),
  .rd_sel(rd_sel), .rd_word(rd_word), .rd_code(rd_code),
  .sector_done(sector_done), .page_done(page_done));

// File: tb/sim_sector_parity_page.sv
`timescale 1ns/1ps
module sim_sector_parity_page;
  logic        clk, rst_n, clr, en, din_vld;
  logic [7:0]  din;
  logic [1:0]  rd_sel;
  logic [31:0] rd_word;
  logic [23:0] rd_code;
  logic        sector_done, page_done;

  sector_parity_page u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .din_vld(din_vld),
    .din(din), .rd_sel(rd_sel), .rd_word(rd_word), .rd_code(rd_code),
    .sector_done(sector_done), .page_done(page_done));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int m_cnt = 0, m_slot = 0;
  logic [11:0] m_ev = '0, m_od = '0;
  logic [23:0] m_res [4];
  logic        m_sd = 1'b0, m_pd = 1'b0;
  logic [1:0]  rr = 2'd0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model, bit address = byte*8 + bit
  task automatic model(input logic v, input logic e, input logic c, input logic [7:0] d);
    m_sd = 1'b0; m_pd = 1'b0;
    if (c) begin
      m_cnt = 0; m_slot = 0; m_ev = '0; m_od = '0;
      foreach (m_res[i]) m_res[i] = '0;
    end else if (v && e) begin
      for (int b = 0; b < 8; b++) begin
        int a = m_cnt * 8 + b;
        if (d[b])
          for (int k = 0; k < 12; k++)
            if (((a >> k) & 1) == 1) m_od[k] = ~m_od[k]; else m_ev[k] = ~m_ev[k];
      end
      if (m_cnt == 511) begin
        m_res[m_slot] = {m_od, m_ev};
        m_ev = '0; m_od = '0; m_cnt = 0; m_sd = 1'b1;
        m_pd = (m_slot == 3);
        m_slot = (m_slot + 1) % 4;
      end else m_cnt++;
    end
  endtask

  task automatic compare();
    logic [23:0] r = m_res[rd_sel];
    chk("R3 R6 R10 word", rd_word, {4'h0, r[23:12], 4'h0, r[11:0]});
    chk("R4 code", {8'h0, rd_code}, {8'h0, r[23:20], r[11:8], r[19:12], r[7:0]});
    chk("R7 sector_done", {31'h0, sector_done}, {31'h0, m_sd});
    chk("R7 page_done", {31'h0, page_done}, {31'h0, m_pd});
  endtask

  task automatic step(input logic v, input logic e, input logic c, input logic [7:0] d);
    @(negedge clk);
    din_vld = v; en = e; clr = c; din = d; rd_sel = rr; rr = rr + 2'd1;
    @(posedge clk);
    model(v, e, c, d);
    #1 compare();
  endtask

  task automatic look(input logic [1:0] s, input logic [31:0] w, input logic [23:0] cd, input string tag);
    @(negedge clk);
    din_vld = 1'b0; en = 1'b0; clr = 1'b0; rd_sel = s;
    #1;
    chk(tag, rd_word, w);
    chk(tag, {8'h0, rd_code}, {8'h0, cd});
  endtask

  // kind 0: single byte 'val' at 'spot', rest zero; kind 1: random
  task automatic feed(input int kind, input int spot, input logic [7:0] val, input bit gaps);
    int i = 0;
    while (i < 512) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 1) step(1'b1, 1'b0, 1'b0, 8'hFF);
        else                           step(1'b0, 1'b1, 1'b0, 8'hFF);
      end else begin
        logic [7:0] d = (kind == 0) ? ((i == spot) ? val : 8'h00) : 8'($urandom);
        step(1'b1, 1'b1, 1'b0, d);
        i++;
      end
    end
  endtask

  initial begin
    foreach (m_res[i]) m_res[i] = '0;
    rst_n = 1'b0; clr = 1'b0; en = 1'b0; din_vld = 1'b0; din = '0; rd_sel = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int s = 0; s < 4; s++) look(2'(s), 32'h0, 24'h0, "R8 reset state");

    step(1'b0, 1'b0, 1'b1, 8'h00);
    feed(0, 300, 8'h20, 1'b0);                     // address 2405
    look(2'd0, 32'h0965069A, 24'h96659A, "R1 R2 R3 R4 single bit");
    feed(0, 0, 8'h01, 1'b0);                       // address 0
    look(2'd1, 32'h00000FFF, 24'h0F00FF, "R1 address zero");
    feed(0, 0, 8'h00, 1'b0);
    look(2'd2, 32'h0, 24'h0, "R5 zero sector");
    feed(1, 0, 8'h00, 1'b1);                       // slot 3, page_done
    feed(1, 0, 8'h00, 1'b1);                       // wraps to slot 0
    look(2'd1, 32'h00000FFF, 24'h0F00FF, "R6 R10 slot 1 kept");

    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b0, 8'($urandom));
    step(1'b1, 1'b1, 1'b1, 8'hFF);                 // clear wins over strobe
    for (int s = 0; s < 4; s++) look(2'(s), 32'h0, 24'h0, "R8 clear");
    feed(0, 0, 8'h00, 1'b1);                       // rejected bytes are FF
    look(2'd0, 32'h0, 24'h0, "R9 rejected bytes");
    feed(1, 0, 8'h00, 1'b1);
    repeat (8) step(1'b0, 1'b0, 1'b0, 8'h00);

    summary();
    $finish;
  end
endmodule